// File: doc/BRIEF.md
# Two-Winding Stepper Phase Sequencer

This block walks an eight-position electrical cycle for a two-phase bipolar stepper motor. For each of the two windings, A and B, it drives a polarity bit and an enable bit. The gate logic of the two H-bridges consumes these bits. The block owns neither current regulation nor gate timing.

Four inputs control it, all asynchronous to the system clock:
- a step clock;
- a rotation direction;
- a half/full-step selector;
- an active-low home input.

Each input passes through a two-flop synchroniser. The step clock is also filtered so that only clean pulses count as steps.

Half-step mode moves one position per step. Full-step mode moves two positions per step, which keeps the parity of the current position. From an odd position, both windings stay energised (two-phase-on). From an even position, only one winding is energised at a time (one-phase-on). To get one-phase-on drive, home the block, give one step in half-step mode, then switch to full-step.

Top module: `step_phase_gen`

## Requirements
- R1: After system reset the block is at position 1. The outputs are a_en=1, a_pol=1, b_en=1, b_pol=1, where pol=1 means positive current.
- R2: While home_ni is held low, the position is forced to 1 and step pulses are ignored.
- R3: Each qualified rising edge of step_clk_i moves the position exactly once. Without a qualified edge, the outputs do not change.
- R4: With half_i=1 and cw_i=1, each step increases the position by one: 1,2,...,8, then back to 1.
- R5: With half_i=1 and cw_i=0, each step decreases the position by one: 1,8,7,...,2, then back to 1.
- R6: With half_i=0 and an odd position, steps visit 1,3,5,7 when cw_i=1 and 1,7,5,3 when cw_i=0. Both windings stay enabled.
- R7: With half_i=0 and an even position, steps visit 2,4,6,8 when cw_i=1 and 8,6,4,2 when cw_i=0. Exactly one winding is enabled at every step.
- R8: The outputs {a_en,a_pol,b_en,b_pol} for positions 1 to 8 are 1111, 0011, 1011, 1000, 1010, 0010, 1110, 1100. A disabled winding reports pol=0.
- R9: A high or low level on step_clk_i shorter than MIN_PULSE system cycles, after synchronisation, is ignored. A short high glitch makes no step. A short low dip inside a high level makes no extra step.
- R10: A step edge recognised within GUARD system cycles after the synchronised home_ni rises is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| step_clk_i | input | 1 | Asynchronous step clock; steps on a qualified rising edge |
| cw_i | input | 1 | Direction: 1 = clockwise (upward), 0 = counterclockwise |
| half_i | input | 1 | Step size: 1 = half-step, 0 = full-step |
| home_ni | input | 1 | Active-low home; forces position 1 |
| a_en_o | output | 1 | Winding A enable |
| a_pol_o | output | 1 | Winding A polarity (1 = positive) |
| b_en_o | output | 1 | Winding B enable |
| b_pol_o | output | 1 | Winding B polarity (1 = positive) |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- **Wrap-around in both directions.** An off-by-one in the modulo-8 arithmetic stalls the walk or skips a position at the 8/1 boundary.
- **Parity of the full-step flavour.** A design that rounds the position to odd before stepping never reaches one-phase-on drive. The bench checks the even walk after the one-half-step entry sequence, from both directions.
- **Pulse-width filter.** A two-cycle glitch and a two-cycle dip inside a long high level must leave the position untouched. A plain edge detector would add a step in either case.
- **Home input.** An edge that coincides with the release of home must be dropped. Steps given while home is held must change nothing. A missing guard, or one counting from the wrong event, lets those edges through.

// File: rtl/step_pkg.sv
package step_pkg;

    // Position index 0..7 stands for positions 1..8
    typedef logic [2:0] pos_t;

    typedef struct packed {
        logic a_en;
        logic a_pol;
        logic b_en;
        logic b_pol;
    } drive_t;

endpackage

// File: rtl/step_sync.sv
module step_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign dout_o = pipe_q[STAGES-1];

endmodule

// File: rtl/step_edge_qual.sv
module step_edge_qual #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);

    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          rise;
    } qual_t;

    qual_t st_d, st_q;

    // The filtered level follows the input only after MIN_PULSE
    // consecutive cycles of disagreement.
    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (level_i != st_q.lvl) begin
            if (st_q.cnt == CW'(MIN_PULSE - 1)) begin
                st_d.lvl  = level_i;
                st_d.cnt  = '0;
                st_d.rise = level_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;

endmodule

// File: rtl/step_pos_core.sv
module step_pos_core
    import step_pkg::*;
#(
    parameter int GUARD = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic cw_i,
    input  logic half_i,
    input  logic home_n_i,
    output pos_t pos_o,
    output logic busy_o
);

    localparam int GW = $clog2(GUARD + 1);

    typedef struct packed {
        pos_t          pos;
        logic [GW-1:0] guard;
    } core_t;

    core_t st_d, st_q;
    pos_t  inc;

    always_comb begin
        if (half_i) begin
            inc = cw_i ? pos_t'(1) : pos_t'(7);
        end else begin
            inc = cw_i ? pos_t'(2) : pos_t'(6);
        end

        st_d = st_q;
        if (!home_n_i) begin
            st_d.pos   = '0;
            st_d.guard = GW'(GUARD);
        end else if (st_q.guard != '0) begin
            st_d.guard = st_q.guard - 1'b1;
        end else if (step_i) begin
            st_d.pos = st_q.pos + inc;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pos   <= '0;
            st_q.guard <= GW'(GUARD);
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign busy_o = (st_q.guard != '0);

endmodule

// File: rtl/step_drive_decode.sv
module step_drive_decode
    import step_pkg::*;
(
    input  pos_t   pos_i,
    output drive_t drv_o
);

    always_comb begin
        unique case (pos_i)
            3'd0:    drv_o = '{a_en: 1'b1, a_pol: 1'b1, b_en: 1'b1, b_pol: 1'b1};
            3'd1:    drv_o = '{a_en: 1'b0, a_pol: 1'b0, b_en: 1'b1, b_pol: 1'b1};
            3'd2:    drv_o = '{a_en: 1'b1, a_pol: 1'b0, b_en: 1'b1, b_pol: 1'b1};
            3'd3:    drv_o = '{a_en: 1'b1, a_pol: 1'b0, b_en: 1'b0, b_pol: 1'b0};
            3'd4:    drv_o = '{a_en: 1'b1, a_pol: 1'b0, b_en: 1'b1, b_pol: 1'b0};
            3'd5:    drv_o = '{a_en: 1'b0, a_pol: 1'b0, b_en: 1'b1, b_pol: 1'b0};
            3'd6:    drv_o = '{a_en: 1'b1, a_pol: 1'b1, b_en: 1'b1, b_pol: 1'b0};
            default: drv_o = '{a_en: 1'b1, a_pol: 1'b1, b_en: 1'b0, b_pol: 1'b0};
        endcase
    end

endmodule

// File: rtl/step_phase_gen.sv
module step_phase_gen
    import step_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 4,
    parameter int GUARD       = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_clk_i,
    input  logic cw_i,
    input  logic half_i,
    input  logic home_ni,
    output logic a_en_o,
    output logic a_pol_o,
    output logic b_en_o,
    output logic b_pol_o
);

    logic [3:0] raw_in, synced;
    logic       step_go;
    logic       guard_busy;
    logic       home_n_s;
    pos_t       pos;
    drive_t     drv;

    assign raw_in   = {step_clk_i, cw_i, half_i, home_ni};
    assign home_n_s = synced[0];

    step_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (4),
        .RST_VAL (4'b0000)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (raw_in),
        .dout_o (synced)
    );

    step_edge_qual #(
        .MIN_PULSE (MIN_PULSE)
    ) i_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (synced[3]),
        .rise_o  (step_go)
    );

    step_pos_core #(
        .GUARD (GUARD)
    ) i_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step_go),
        .cw_i     (synced[2]),
        .half_i   (synced[1]),
        .home_n_i (home_n_s),
        .pos_o    (pos),
        .busy_o   (guard_busy)
    );

    step_drive_decode i_dec (
        .pos_i (pos),
        .drv_o (drv)
    );

    assign a_en_o  = drv.a_en;
    assign a_pol_o = drv.a_pol;
    assign b_en_o  = drv.b_en;
    assign b_pol_o = drv.b_pol;

endmodule

// File: rtl/step_phase_gen_chk.sv
module step_phase_gen_chk
    import step_pkg::*;
(
    input logic clk_i,
    input logic rst_ni,
    input logic home_ni,
    input logic step_go,
    input logic guard_busy,
    input logic home_n_s,
    input pos_t pos,
    input logic a_en_o,
    input logic a_pol_o,
    input logic b_en_o,
    input logic b_pol_o
);

    logic [1:0] home_low_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            home_low_cnt <= '0;
        end else if (home_ni) begin
            home_low_cnt <= '0;
        end else if (home_low_cnt != 2'd3) begin
            home_low_cnt <= home_low_cnt + 1'b1;
        end
    end

    // R2: a home input held low settles on position 1 at the outputs
    p_home_state1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (home_low_cnt == 2'd3) |-> ({a_en_o, a_pol_o, b_en_o, b_pol_o} == 4'b1111));

    // R3: outputs hold when no step is taken and home is inactive
    p_hold_without_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_go && home_n_s) |=> $stable({a_en_o, a_pol_o, b_en_o, b_pol_o}));

    // R3: an accepted step moves by one or two positions only
    p_single_notch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_go && home_n_s && !guard_busy)
        |=> (pos_t'(pos - $past(pos)) inside {3'd1, 3'd2, 3'd6, 3'd7}));

    // R8: at least one winding is always energised
    p_one_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_en_o || b_en_o);

    // R10: no movement while the post-home guard is running
    p_guard_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (guard_busy && home_n_s) |=> $stable(pos));

endmodule

bind step_phase_gen step_phase_gen_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .home_ni    (home_ni),
    .step_go    (step_go),
    .guard_busy (guard_busy),
    .home_n_s   (home_n_s),
    .pos        (pos),
    .a_en_o     (a_en_o),
    .a_pol_o    (a_pol_o),
    .b_en_o     (b_en_o),
    .b_pol_o    (b_pol_o)
);

// File: tb/test_step_phase_gen.sv
module test_step_phase_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_clk = 1'b0;
    logic cw = 1'b1;
    logic half = 1'b1;
    logic home_n = 1'b1;
    logic a_en, a_pol, b_en, b_pol;

    int n_checks = 0;
    int n_fail   = 0;
    int cur      = 1;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    step_phase_gen i_step_phase_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .step_clk_i (step_clk),
        .cw_i       (cw),
        .half_i     (half),
        .home_ni    (home_n),
        .a_en_o     (a_en),
        .a_pol_o    (a_pol),
        .b_en_o     (b_en),
        .b_pol_o    (b_pol)
    );

    function automatic logic [3:0] exp_pat(int p);
        case (p)
            1:       return 4'b1111;
            2:       return 4'b0011;
            3:       return 4'b1011;
            4:       return 4'b1000;
            5:       return 4'b1010;
            6:       return 4'b0010;
            7:       return 4'b1110;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int p);
        logic [3:0] got;
        got = {a_en, a_pol, b_en, b_pol};
        n_checks++;
        if (got !== exp_pat(p)) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b (position %0d)", req, got, exp_pat(p), p);
        end
    endtask

    task automatic do_step();
        step_clk = 1'b1;
        wait_cyc(12);
        step_clk = 1'b0;
        wait_cyc(12);
    endtask

    task automatic go_home();
        home_n = 1'b0;
        wait_cyc(10);
        home_n = 1'b1;
        wait_cyc(30);
        cur = 1;
    endtask

    function automatic int advance(int p, int delta);
        return ((p - 1 + delta + 8) % 8) + 1;
    endfunction

    task automatic t_reset();
        wait_cyc(30);
        check("R1 reset state", 1);
    endtask

    task automatic t_half_cw();
        go_home();
        half = 1'b1; cw = 1'b1;
        for (int i = 0; i < 8; i++) begin
            do_step();
            cur = advance(cur, 1);
            check("R4 half cw (R3, R8)", cur);
        end
    endtask

    task automatic t_half_ccw();
        go_home();
        half = 1'b1; cw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            do_step();
            cur = advance(cur, -1);
            check("R5 half ccw (R8)", cur);
        end
    endtask

    task automatic t_full_odd();
        go_home();
        half = 1'b0; cw = 1'b1;
        for (int i = 0; i < 4; i++) begin
            do_step();
            cur = advance(cur, 2);
            check("R6 full odd cw", cur);
        end
        cw = 1'b0;
        for (int i = 0; i < 4; i++) begin
            do_step();
            cur = advance(cur, -2);
            check("R6 full odd ccw", cur);
        end
    endtask

    task automatic t_wave();
        go_home();
        half = 1'b1; cw = 1'b1;
        do_step();
        cur = 2;
        check("R7 wave entry cw", cur);
        half = 1'b0;
        for (int i = 0; i < 4; i++) begin
            do_step();
            cur = advance(cur, 2);
            check("R7 wave cw", cur);
        end
        cw = 1'b0;
        for (int i = 0; i < 4; i++) begin
            do_step();
            cur = advance(cur, -2);
            check("R7 wave ccw", cur);
        end
        go_home();
        half = 1'b1; cw = 1'b0;
        do_step();
        cur = 8;
        check("R7 wave entry ccw", cur);
        half = 1'b0;
        do_step();
        cur = 6;
        check("R7 wave ccw from 8", cur);
    endtask

    task automatic t_glitch();
        go_home();
        half = 1'b1; cw = 1'b1;
        step_clk = 1'b1;
        wait_cyc(2);
        step_clk = 1'b0;
        wait_cyc(20);
        check("R9 short high glitch ignored", cur);
        step_clk = 1'b1;
        wait_cyc(20);
        cur = 2;
        check("R9 long high accepted", cur);
        step_clk = 1'b0;
        wait_cyc(2);
        step_clk = 1'b1;
        wait_cyc(20);
        check("R9 short low dip ignored", cur);
        wait_cyc(40);
        check("R3 no change while idle", cur);
        step_clk = 1'b0;
        wait_cyc(20);
    endtask

    task automatic t_guard();
        half = 1'b1; cw = 1'b1;
        home_n = 1'b0;
        wait_cyc(10);
        home_n   = 1'b1;
        step_clk = 1'b1;
        wait_cyc(12);
        step_clk = 1'b0;
        wait_cyc(30);
        cur = 1;
        check("R10 edge at home release dropped", cur);
        do_step();
        cur = 2;
        check("R10 step after guard accepted", cur);
    endtask

    task automatic t_home_hold();
        half = 1'b1; cw = 1'b1;
        do_step();
        home_n = 1'b0;
        wait_cyc(10);
        check("R2 home forces position 1", 1);
        do_step();
        do_step();
        check("R2 steps ignored while home held", 1);
        home_n = 1'b1;
        wait_cyc(30);
        cur = 1;
        check("R2 position 1 after home release", cur);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_half_cw();
        t_half_ccw();
        t_full_odd();
        t_wave();
        t_glitch();
        t_guard();
        t_home_hold();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
    end

endmodule